// File: doc/BRIEF.md
# Fractional Clock-Enable Rate Generator

This block is the rate datapath of a root clock generator. It works entirely with clock-enable pulses in one clock domain. A 3-bit code picks one of eight incoming enable streams. A pre-divider then thins that stream by a ratio that can be a half-integer. An optional fractional stage can follow it. That stage emits m output pulses for every n pre-divided pulses, and it drives a level output whose high fraction is set by a duty value.

The configuration inputs come straight from the active register copy: the pre-divider field, the source code, a 2-bit mode, and the M, N and D words. N and D are stored in inverted form. N holds the bitwise inverse of (n − m), and the block recovers n by adding m back. D holds the bitwise inverse of the duty threshold. The overall output rate is input × (m/n) × 2/(k+1), where k is the pre-divider field.

Top module: `frac_clk_gen`

## Requirements
- R1: While reset is held, `tick_o` and `level_o` are both 0.
- R2: `src_sel_i` chooses input enable bit `src_en_i[src_sel_i]`. The other enable bits have no effect on the outputs.
- R3: A pre-divider field of 0 bypasses the pre-divider, so every selected input enable produces one pre-divided pulse.
- R4: A pre-divider field k ≥ 1 produces exactly 2 pre-divided pulses for every k+1 selected input enables, counted from reset.
- R5: With the selected source continuously high, the spacing between successive pre-divided pulses is always floor((k+1)/2) or ceil((k+1)/2) cycles.
- R6: The fractional stage acts only when `mode_i` equals 2'b10. With any other mode, each pre-divided pulse passes to `tick_o` one cycle later.
- R7: With the fractional stage active, n = (~`n_enc_i` + `m_i`) mod 2^MNDW. The phase advances by m on each pre-divided pulse and wraps at n. A wrap produces one `tick_o` pulse, so the stage gives exactly m ticks per n pre-divided pulses, counted from reset.
- R8: If m = 0 or the decoded n = 0, the fractional stage is bypassed whatever the mode is.
- R9: With the fractional stage active, `level_o` is 1 exactly when 2·phase < ~`d_enc_i`. Setting `d_enc_i` = ~n gives a 50% high fraction.
- R10: While the fractional stage is bypassed, `level_o` equals `tick_o`.
- R11: A selected enable that is high before clock edge e appears on `tick_o` after edge e+1. With a field of 0 in bypass, this is two register stages of latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| src_en_i | input | NSRC (8) | Candidate enable streams |
| src_sel_i | input | SELW (3) | Index of the enable stream to use |
| div_i | input | DIVW (5) | Half-integer pre-divider field k; ratio (k+1)/2, 0 = bypass |
| mode_i | input | 2 | Stage mode; 2'b10 enables the fractional stage |
| m_i | input | MNDW (8) | Numerator m |
| n_enc_i | input | MNDW (8) | Inverse of (n − m) |
| d_enc_i | input | MNDW (8) | Inverse of the duty threshold |
| tick_o | output | 1 | Output enable pulse |
| level_o | output | 1 | Duty-shaped level, or a copy of tick in bypass |

## Verification
The bench sweeps every pre-divider field and checks the pulse count for each. A pre-divider that truncated the half step would lose pulses on even fields. A pre-divider that failed to alternate would break the spacing bound. The bench also sweeps m from 0 up to n over a range of n values. Here a wrong inverse decode of N, or a wrap without the remainder, shows up as a wrong tick count. The m = 0, n = 0 and non-dual modes must all fall back to the pre-divider, and a missing bypass would leave the output silent or at the fractional rate. Duty runs count the high cycles of the level against the phase set; a threshold compared without the doubling would give the wrong fraction. The single-pulse latency test and the noisy unselected sources catch an extra or missing register and a wrong select index.

// File: rtl/frac_div_pkg.sv
package frac_div_pkg;
    // Mode code that turns on the fractional stage
    localparam logic [1:0] MODE_DUAL_EDGE = 2'b10;
    // Pre-divider step, in half units, added per input enable
    localparam int HALF_STEP = 2;
endpackage

// File: rtl/fd_src_pick.sv
module fd_src_pick #(
    parameter int NSRC = 8,
    parameter int SELW = 3
) (
    input  logic [NSRC-1:0] en_i,
    input  logic [SELW-1:0] sel_i,
    output logic            en_o
);
    always_comb begin
        en_o = 1'b0;
        for (int i = 0; i < NSRC; i++) begin
            if (sel_i == SELW'(i)) en_o = en_i[i];
        end
    end
endmodule

// File: rtl/fd_half_prediv.sv
module fd_half_prediv
    import frac_div_pkg::*;
#(
    parameter int DIVW = 5
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            en_i,
    input  logic [DIVW-1:0] div_i,
    output logic            tick_o
);
    localparam int ACCW = DIVW + 2;

    typedef struct packed {
        logic [ACCW-1:0] acc;
        logic            tick;
    } pd_st_t;

    pd_st_t st_d, st_q;
    logic [ACCW-1:0] lim, sum, rem;

    always_comb begin
        st_d      = st_q;
        st_d.tick = 1'b0;
        lim = ACCW'(div_i) + ACCW'(1);
        sum = st_q.acc + ACCW'(HALF_STEP);
        rem = sum - lim;
        if (div_i == '0) begin
            st_d.acc  = '0;
            st_d.tick = en_i;
        end else if (en_i) begin
            if (sum >= lim) begin
                st_d.tick = 1'b1;
                st_d.acc  = (rem >= lim) ? '0 : rem;
            end else begin
                st_d.acc = sum;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign tick_o = st_q.tick;
endmodule

// File: rtl/fd_mnd_stage.sv
module fd_mnd_stage
    import frac_div_pkg::*;
#(
    parameter int MNDW = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            tick_i,
    input  logic [1:0]      mode_i,
    input  logic [MNDW-1:0] m_i,
    input  logic [MNDW-1:0] n_enc_i,
    input  logic [MNDW-1:0] d_enc_i,
    output logic            tick_o,
    output logic            level_o,
    output logic            active_o,
    output logic [MNDW-1:0] phase_o
);
    localparam int SUMW = MNDW + 1;

    typedef struct packed {
        logic [MNDW-1:0] phase;
        logic            tick;
        logic            level;
    } mnd_st_t;

    mnd_st_t st_d, st_q;
    logic [MNDW-1:0] n_dec, thr;
    logic [SUMW-1:0] sum, rem;
    logic            active;

    always_comb begin
        n_dec  = ~n_enc_i + m_i;
        thr    = ~d_enc_i;
        active = (mode_i == MODE_DUAL_EDGE) && (m_i != '0) && (n_dec != '0);
        sum    = {1'b0, st_q.phase} + {1'b0, m_i};
        rem    = sum - {1'b0, n_dec};

        st_d      = st_q;
        st_d.tick = 1'b0;
        if (!active) begin
            st_d.phase = '0;
            st_d.tick  = tick_i;
            st_d.level = tick_i;
        end else begin
            if (tick_i) begin
                if (sum >= {1'b0, n_dec}) begin
                    st_d.tick  = 1'b1;
                    st_d.phase = (rem >= {1'b0, n_dec}) ? '0 : rem[MNDW-1:0];
                end else begin
                    st_d.phase = sum[MNDW-1:0];
                end
            end
            st_d.level = ({st_d.phase, 1'b0} < {1'b0, thr});
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign tick_o   = st_q.tick;
    assign level_o  = st_q.level;
    assign active_o = active;
    assign phase_o  = st_q.phase;
endmodule

// File: rtl/frac_clk_gen.sv
module frac_clk_gen #(
    parameter int NSRC = 8,
    parameter int DIVW = 5,
    parameter int MNDW = 8,
    localparam int SELW = (NSRC > 1) ? $clog2(NSRC) : 1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [NSRC-1:0] src_en_i,
    input  logic [SELW-1:0] src_sel_i,
    input  logic [DIVW-1:0] div_i,
    input  logic [1:0]      mode_i,
    input  logic [MNDW-1:0] m_i,
    input  logic [MNDW-1:0] n_enc_i,
    input  logic [MNDW-1:0] d_enc_i,
    output logic            tick_o,
    output logic            level_o
);
    logic            sel_en;
    logic            pre_tick;
    logic            mnd_active;
    logic [MNDW-1:0] mnd_phase;

    fd_src_pick #(.NSRC(NSRC), .SELW(SELW)) u_pick (
        .en_i  (src_en_i),
        .sel_i (src_sel_i),
        .en_o  (sel_en)
    );

    fd_half_prediv #(.DIVW(DIVW)) u_prediv (
        .clk    (clk),
        .rst    (rst),
        .en_i   (sel_en),
        .div_i  (div_i),
        .tick_o (pre_tick)
    );

    fd_mnd_stage #(.MNDW(MNDW)) u_mnd (
        .clk      (clk),
        .rst      (rst),
        .tick_i   (pre_tick),
        .mode_i   (mode_i),
        .m_i      (m_i),
        .n_enc_i  (n_enc_i),
        .d_enc_i  (d_enc_i),
        .tick_o   (tick_o),
        .level_o  (level_o),
        .active_o (mnd_active),
        .phase_o  (mnd_phase)
    );
endmodule

// File: rtl/frac_clk_gen_chk.sv
module frac_clk_gen_chk #(
    parameter int DIVW = 5,
    parameter int MNDW = 8
) (
    input logic            clk,
    input logic            rst,
    input logic            sel_en,
    input logic            pre_tick,
    input logic [DIVW-1:0] div_i,
    input logic [1:0]      mode_i,
    input logic [MNDW-1:0] m_i,
    input logic [MNDW-1:0] n_enc_i,
    input logic            mnd_active,
    input logic [MNDW-1:0] mnd_phase,
    input logic            tick_o,
    input logic            level_o
);
    logic [MNDW-1:0] n_chk;
    assign n_chk = ~n_enc_i + m_i;

    // R2
    pre_from_sel_chk: assert property (@(posedge clk) disable iff (rst)
        pre_tick |-> $past(sel_en));

    // R3
    bypass_follow_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(div_i) == '0) |-> pre_tick == $past(sel_en));

    // R11
    out_from_pre_chk: assert property (@(posedge clk) disable iff (rst)
        tick_o |-> $past(pre_tick));

    // R6
    mode_pass_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(mode_i) != 2'b10) |-> tick_o == $past(pre_tick));

    // R10
    byp_level_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(mnd_active)) |-> level_o == tick_o);

    // R7
    phase_bound_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && mnd_active && $past(mnd_active) && $past(pre_tick)
         && $stable(m_i) && $stable(n_enc_i)) |-> mnd_phase < n_chk);
endmodule

bind frac_clk_gen frac_clk_gen_chk #(.DIVW(DIVW), .MNDW(MNDW)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .sel_en     (sel_en),
    .pre_tick   (pre_tick),
    .div_i      (div_i),
    .mode_i     (mode_i),
    .m_i        (m_i),
    .n_enc_i    (n_enc_i),
    .mnd_active (mnd_active),
    .mnd_phase  (mnd_phase),
    .tick_o     (tick_o),
    .level_o    (level_o)
);

// File: tb/tb_frac_clk_gen.sv
`timescale 1ns/1ps
module tb_frac_clk_gen;
    localparam int NSRC = 8;
    localparam int DIVW = 5;
    localparam int MNDW = 8;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [NSRC-1:0] src_en = '0;
    logic [2:0]      src_sel = '0;
    logic [DIVW-1:0] div = '0;
    logic [1:0]      mode = '0;
    logic [MNDW-1:0] m = '0;
    logic [MNDW-1:0] n_enc = '0;
    logic [MNDW-1:0] d_enc = '0;
    logic            tick, level;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    frac_clk_gen #(.NSRC(NSRC), .DIVW(DIVW), .MNDW(MNDW)) dut (
        .clk(clk), .rst(rst), .src_en_i(src_en), .src_sel_i(src_sel),
        .div_i(div), .mode_i(mode), .m_i(m), .n_enc_i(n_enc), .d_enc_i(d_enc),
        .tick_o(tick), .level_o(level)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic set_cfg(input int s, input int k, input int md, input int mm,
                           input int nn, input int dv);
        logic [MNDW-1:0] diff;
        diff    = MNDW'(nn - mm);
        src_sel = 3'(s);
        div     = DIVW'(k);
        mode    = 2'(md);
        m       = MNDW'(mm);
        n_enc   = ~diff;
        d_enc   = ~MNDW'(dv);
    endtask

    // Reset, then feed P enables on the selected bit while all other bits stay high.
    task automatic run_case(input string req, input int s, input int k, input int md,
                            input int mm, input int nn, input int p, input int exp,
                            input bit chk_gap, input bit chk_lvl);
        int cnt, last, mis, gap_bad, lo, hi;
        @(negedge clk);
        rst = 1'b1;
        set_cfg(s, k, md, mm, nn, nn);
        src_en = ~(NSRC'(1) << s);
        repeat (2) @(negedge clk);
        rst = 1'b0;
        cnt = 0; last = -1; mis = 0; gap_bad = 0;
        lo = (k + 1) / 2; hi = (k + 2) / 2;
        for (int c = 0; c < p + 6; c++) begin
            @(negedge clk);
            if (tick) begin
                if (last >= 0 && (c - last < lo || c - last > hi)) gap_bad++;
                last = c;
                cnt++;
            end
            if (level !== tick) mis++;
            src_en[s] = (c < p);
        end
        chk(cnt == exp, req, cnt, exp);
        if (chk_gap) chk(gap_bad == 0, "R5 spacing", gap_bad, 0);
        if (chk_lvl) chk(mis == 0, "R10 level follows tick", mis, 0);
    endtask

    // Continuous source, fractional stage on, count level-high cycles over n*L updates.
    task automatic duty_case(input int mm, input int nn, input int dv, input int l);
        int hi_cnt, exp;
        @(negedge clk);
        rst = 1'b1;
        set_cfg(0, 0, 2, mm, nn, dv);
        src_en = '1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        repeat (2) @(posedge clk);
        hi_cnt = 0;
        for (int i = 0; i < nn * l; i++) begin
            #1;
            if (level) hi_cnt++;
            @(posedge clk);
        end
        exp = 0;
        for (int j = 0; j < nn; j++) if (2 * ((j * mm) % nn) < dv) exp += l;
        chk(hi_cnt == exp, "R9 duty", hi_cnt, exp);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        // R1: outputs idle in reset
        set_cfg(0, 0, 0, 0, 0, 0);
        src_en = '1;
        repeat (3) @(negedge clk);
        chk(tick == 1'b0, "R1 tick in reset", int'(tick), 0);
        chk(level == 1'b0, "R1 level in reset", int'(level), 0);

        // R11: single enable, latency of two edges
        @(negedge clk);
        set_cfg(1, 0, 0, 0, 0, 0);
        src_en = '0;
        rst = 1'b0;
        repeat (2) @(negedge clk);
        src_en[1] = 1'b1;
        @(negedge clk);
        src_en[1] = 1'b0;
        chk(tick == 1'b0, "R11 before", int'(tick), 0);
        @(negedge clk);
        chk(tick == 1'b1, "R11 arrival", int'(tick), 1);
        @(negedge clk);
        chk(tick == 1'b0, "R11 single", int'(tick), 0);

        // R2 R3 R4 R5 R10: every pre-divider field, rotating selects, mode 0
        for (int k = 0; k < (1 << DIVW); k++) begin
            int p;
            p = (k + 1) * 4;
            run_case(k == 0 ? "R3 bypass count" : "R4 prediv count R2",
                     k % NSRC, k, 0, 0, 0, p, (k == 0) ? p : 8, k >= 1, 1'b1);
        end

        // R7 R8: fractional sweep, m from 0 to n
        for (int nn = 1; nn <= 10; nn++) begin
            for (int mm = 0; mm <= nn; mm++) begin
                run_case(mm == 0 ? "R8 m zero" : "R7 mnd count", 3, 0, 2, mm, nn,
                         nn * 3, (mm == 0) ? nn * 3 : mm * 3, 1'b0, mm == 0);
            end
        end

        // R6: non-dual modes ignore M/N
        run_case("R6 mode 0", 5, 0, 0, 3, 5, 20, 20, 1'b0, 1'b1);
        run_case("R6 mode 1", 6, 0, 1, 3, 5, 20, 20, 1'b0, 1'b1);
        run_case("R6 mode 3", 7, 0, 3, 3, 5, 20, 20, 1'b0, 1'b1);

        // R8: decoded n of zero
        run_case("R8 n zero", 2, 0, 2, 3, 0, 20, 20, 1'b0, 1'b1);

        // R4 with R7: half-integer prediv then fraction 1/2
        run_case("R4 R7 cascade", 4, 2, 2, 1, 2, 12, 4, 1'b0, 1'b0);
        run_case("R4 R7 cascade odd", 0, 5, 2, 2, 5, 60, 8, 1'b0, 1'b0);

        // R9: duty from the threshold
        duty_case(1, 8, 8, 2);
        duty_case(3, 8, 8, 2);
        duty_case(1, 10, 3, 2);
        duty_case(2, 6, 6, 2);
        duty_case(5, 9, 14, 2);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule